// File: doc/BRIEF.md
# Interrupt Status Collector

This block gathers interrupt causes into one 32-bit sticky status word and turns that word into a request to the host. Two hardware engines report completion with single-cycle pulses: a compute engine and a transfer engine. Software sees the word through a small register window. It can read the word, inject causes through a raise register, and acknowledge causes through a clear register.

Delivery depends on the `msi_en_i` input. When message-signalled delivery is off, the block drives a level line. The line rises on any raise that leaves the word nonzero, and it falls when a clear empties the word. When message-signalled delivery is on, every raise that leaves the word nonzero produces a one-cycle request pulse, even if the bits involved were already set. In that mode the level line is left untouched. The block only produces the request pulse; the bus message itself is formed elsewhere.

All outputs are registered. A register write or engine pulse that is present at a clock edge shows up in the status word, the line and the request pulse right after that same edge. A read strobe returns the status word as it stood before that edge's update.

Top module: `irq_collector`

## Requirements
- R1: While `rst` is high at a clock edge, the status word, `irq_line_o`, `msi_req_o` and `rd_data_o` all become zero after that edge.
- R2: A read strobe at address 0x24 loads `rd_data_o` with the status word as it was before that edge. A read strobe at any other address loads zero. `rd_data_o` holds its value between reads.
- R3: A write to address 0x60 ORs the write data into the status word. Bits that are already set stay set.
- R4: A write to address 0x64 clears every status bit whose write-data bit is 1. The other bits are kept.
- R5: A pulse on `calc_done_i` sets status bit 0 (value 0x1). A pulse on `xfer_done_i` sets status bit 8 (value 0x100).
- R6: If an engine pulse and a clear write target the same bit in the same cycle, the bit ends up set.
- R7: With `msi_en_i` high, a raise event leaves the status word nonzero after the edge. A raise event is an engine pulse or any write to 0x60, including one with zero data. Such an event makes `msi_req_o` high for exactly the following cycle. There is no pulse when the word stays zero.
- R8: With `msi_en_i` low, a raise event that leaves the status word nonzero sets `irq_line_o` after that edge, and `msi_req_o` stays low.
- R9: With `msi_en_i` low, a clear write that leaves the status word zero lowers `irq_line_o`. A clear that leaves bits set keeps the line high.
- R10: While `msi_en_i` is high, `irq_line_o` keeps its value through raises and clears.
- R11: Writes to any address other than 0x60 and 0x64, including the status address 0x24, change neither the status word nor either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| calc_done_i | input | 1 | Compute engine completion pulse |
| xfer_done_i | input | 1 | Transfer engine completion pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Registered read data |
| msi_en_i | input | 1 | Selects message-signalled delivery |
| irq_line_o | output | 1 | Level interrupt line |
| msi_req_o | output | 1 | One-cycle message request pulse |

## Verification
A raise, a clear or an engine pulse that is present at an edge changes the status word, `irq_line_o` and `msi_req_o` right after that edge. A read returns its data right after its own strobe edge. The bench drives every input at the falling edge and holds it through exactly one rising edge. It checks both outputs at the next falling edge, which is the only window in which a one-cycle request pulse can be seen. It then reads the word back in a separate cycle, so that each value the bench expects is settled by exactly one edge.

// File: rtl/irq_pkg.sv
package irq_pkg;

  localparam int unsigned REG_ADDR_W   = 8;
  localparam int unsigned STAT_W       = 32;

  localparam logic [REG_ADDR_W-1:0] ADDR_STATUS = 8'h24;
  localparam logic [REG_ADDR_W-1:0] ADDR_RAISE  = 8'h60;
  localparam logic [REG_ADDR_W-1:0] ADDR_CLEAR  = 8'h64;

  localparam int unsigned CALC_SRC_BIT = 0;
  localparam int unsigned XFER_SRC_BIT = 8;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_RAISE,
    SEL_CLEAR
  } reg_sel_e;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode #(
  parameter int unsigned AW = irq_pkg::REG_ADDR_W,
  parameter logic [AW-1:0] A_STATUS = irq_pkg::ADDR_STATUS,
  parameter logic [AW-1:0] A_RAISE  = irq_pkg::ADDR_RAISE,
  parameter logic [AW-1:0] A_CLEAR  = irq_pkg::ADDR_CLEAR
) (
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  output logic          raise_stb,
  output logic          clear_stb,
  output logic          status_rd
);
  import irq_pkg::*;

  reg_sel_e sel;

  always_comb begin
    unique case (addr)
      A_STATUS: sel = SEL_STATUS;
      A_RAISE:  sel = SEL_RAISE;
      A_CLEAR:  sel = SEL_CLEAR;
      default:  sel = SEL_NONE;
    endcase
  end

  assign raise_stb = wr && (sel == SEL_RAISE);
  assign clear_stb = wr && (sel == SEL_CLEAR);
  assign status_rd = rd && (sel == SEL_STATUS);

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int unsigned W = irq_pkg::STAT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] st_q,
  output logic         nxt_nonzero
);
  logic [W-1:0] nxt;

  for (genvar b = 0; b < W; b++) begin : g_bit
    // a set in the same cycle dominates a clear of the same bit
    assign nxt[b] = set_vec[b] | (st_q[b] & ~clr_vec[b]);

    always_ff @(posedge clk) begin
      if (rst) st_q[b] <= 1'b0;
      else     st_q[b] <= nxt[b];
    end
  end

  assign nxt_nonzero = |nxt;

endmodule

// File: rtl/irq_deliver.sv
module irq_deliver (
  input  logic clk,
  input  logic rst,
  input  logic msi_en,
  input  logic raise_evt,
  input  logic clear_evt,
  input  logic nxt_nonzero,
  output logic line_q,
  output logic msi_q
);
  logic line_set, line_clr;

  assign line_set = raise_evt && nxt_nonzero && !msi_en;
  assign line_clr = clear_evt && !nxt_nonzero && !msi_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b0;
      msi_q  <= 1'b0;
    end else begin
      msi_q <= raise_evt && nxt_nonzero && msi_en;
      if (line_set)      line_q <= 1'b1;
      else if (line_clr) line_q <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_collector.sv
module irq_collector #(
  parameter int unsigned ADDR_W   = irq_pkg::REG_ADDR_W,
  parameter int unsigned DATA_W   = irq_pkg::STAT_W,
  parameter int unsigned CALC_BIT = irq_pkg::CALC_SRC_BIT,
  parameter int unsigned XFER_BIT = irq_pkg::XFER_SRC_BIT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              calc_done_i,
  input  logic              xfer_done_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              msi_en_i,
  output logic              irq_line_o,
  output logic              msi_req_o
);
  logic              raise_stb, clear_stb, status_rd;
  logic [DATA_W-1:0] hw_vec, set_vec, clr_vec, status_q;
  logic              nxt_nonzero, raise_evt;

  irq_reg_decode #(.AW(ADDR_W)) u_dec (
    .wr        (reg_wr_i),
    .rd        (reg_rd_i),
    .addr      (reg_addr_i),
    .raise_stb (raise_stb),
    .clear_stb (clear_stb),
    .status_rd (status_rd)
  );

  always_comb begin
    hw_vec           = '0;
    hw_vec[CALC_BIT] = calc_done_i;
    hw_vec[XFER_BIT] = hw_vec[XFER_BIT] | xfer_done_i;
  end

  assign set_vec   = hw_vec | (raise_stb ? reg_wdata_i : '0);
  assign clr_vec   = clear_stb ? reg_wdata_i : '0;
  assign raise_evt = raise_stb | calc_done_i | xfer_done_i;

  irq_status_reg #(.W(DATA_W)) u_st (
    .clk         (clk),
    .rst         (rst),
    .set_vec     (set_vec),
    .clr_vec     (clr_vec),
    .st_q        (status_q),
    .nxt_nonzero (nxt_nonzero)
  );

  irq_deliver u_dlv (
    .clk         (clk),
    .rst         (rst),
    .msi_en      (msi_en_i),
    .raise_evt   (raise_evt),
    .clear_evt   (clear_stb),
    .nxt_nonzero (nxt_nonzero),
    .line_q      (irq_line_o),
    .msi_q       (msi_req_o)
  );

  always_ff @(posedge clk) begin
    if (rst)           rd_data_o <= '0;
    else if (reg_rd_i) rd_data_o <= status_rd ? status_q : '0;
  end

endmodule

// File: rtl/irq_collector_chk.sv
module irq_collector_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         msi_en,
  input logic         line,
  input logic         msi,
  input logic [W-1:0] status,
  input logic         clr_stb
);
  // R1: reset empties the word and silences both outputs
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (status == '0) && !line && !msi);

  // R3: without a clear write no status bit can drop
  assert_sticky_bits_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(clr_stb)) |-> ((status & $past(status)) == $past(status)));

  // R7: a message request only accompanies a nonzero word
  assert_msi_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
    msi |-> (status != '0));

  // R8: no message request when message delivery was off
  assert_msi_mode_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(msi_en)) |-> !msi);

  // R9: the line only falls onto an empty word
  assert_line_fall_empty_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(line)) |-> (status == '0));

  // R10: line is frozen while message delivery is on
  assert_line_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(msi_en)) |-> $stable(line));

endmodule

bind irq_collector irq_collector_chk #(.W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .msi_en  (msi_en_i),
  .line    (irq_line_o),
  .msi     (msi_req_o),
  .status  (status_q),
  .clr_stb (clear_stb)
);

// File: tb/sim_irq_collector.sv
module sim_irq_collector;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        calc = 1'b0, xfer = 1'b0, wr = 1'b0, rd = 1'b0, msi_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        line, msi;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_st = '0;
  logic        m_line = 1'b0;
  logic [31:0] lfsr = 32'h1357_9bdf;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_collector u0 (
    .clk(clk), .rst(rst), .calc_done_i(calc), .xfer_done_i(xfer),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .rd_data_o(rdata), .msi_en_i(msi_en), .irq_line_o(line), .msi_req_o(msi)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic read_reg(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic check_status(string tag);
    logic [31:0] d;
    read_reg(8'h24, d);
    check(tag, d, m_st);
  endtask

  // one cycle of stimulus; model computed from the requirements
  task automatic step(logic w, logic [7:0] a, logic [31:0] d, logic c, logic x, string tag);
    logic        r_ev, c_ev, exp_msi;
    logic [31:0] setm, clrm, nxt;
    r_ev = (w && a == 8'h60) || c || x;
    c_ev = w && a == 8'h64;
    setm = ((w && a == 8'h60) ? d : 32'h0) | (c ? 32'h1 : 32'h0) | (x ? 32'h100 : 32'h0);
    clrm = c_ev ? d : 32'h0;
    nxt  = setm | (m_st & ~clrm);
    exp_msi = r_ev && nxt != 0 && msi_en;
    if (!msi_en && r_ev && nxt != 0)     m_line = 1'b1;
    else if (!msi_en && c_ev && nxt == 0) m_line = 1'b0;
    m_st = nxt;
    @(negedge clk); wr = w; addr = a; wdata = d; calc = c; xfer = x;
    @(negedge clk); wr = 1'b0; calc = 1'b0; xfer = 1'b0; wdata = '0;
    check({tag, (msi_en ? " R7 msi" : " R8 msi")}, {31'h0, msi}, {31'h0, exp_msi});
    check({tag, (msi_en ? " R10 line" : " R9 line")}, {31'h0, line}, {31'h0, m_line});
    check_status({tag, " status"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 line", {31'h0, line}, 32'h0);
    check("R1 msi", {31'h0, msi}, 32'h0);
    check("R1 rdata", rdata, 32'h0);
    check_status("R1 status");

    // R3/R8 single-bit raises in legacy mode, R4/R9 clears
    for (int b = 0; b < 32; b++) begin
      step(1'b1, 8'h60, 32'h1 << b, 1'b0, 1'b0, "R3 raise");
      step(1'b1, 8'h64, 32'h1 << b, 1'b0, 1'b0, "R4 clear");
    end
    // R5 engine pulses
    step(1'b0, 8'h00, 32'h0, 1'b1, 1'b0, "R5 calc");
    step(1'b0, 8'h00, 32'h0, 1'b0, 1'b1, "R5 xfer");
    // R9 partial clear keeps line, full clear drops it
    step(1'b1, 8'h64, 32'h1, 1'b0, 1'b0, "R9 partial");
    step(1'b1, 8'h64, 32'h100, 1'b0, 1'b0, "R9 full");
    // R6 set beats clear
    step(1'b1, 8'h64, 32'hffff_ffff, 1'b1, 1'b0, "R6 calc-vs-clear");
    step(1'b1, 8'h64, 32'h100, 1'b0, 1'b1, "R6 xfer-vs-clear");
    // R2 read of another address returns zero; data holds after
    read_reg(8'h28, d);
    check("R2 other addr", d, 32'h0);
    @(negedge clk);
    check("R2 hold", rdata, 32'h0);
    // R11 ignored writes
    step(1'b1, 8'h24, 32'h0, 1'b0, 1'b0, "R11 wr status");
    step(1'b1, 8'h68, 32'hffff_ffff, 1'b0, 1'b0, "R11 wr other");
    // R7/R10 message mode: repeated and zero-data raises
    msi_en = 1'b1;
    step(1'b1, 8'h60, 32'h0, 1'b0, 1'b0, "R7 zero raise");
    step(1'b1, 8'h60, 32'h1, 1'b0, 1'b0, "R7 repeat raise");
    step(1'b1, 8'h64, 32'hffff_ffff, 1'b0, 1'b0, "R10 clear all");
    step(1'b1, 8'h60, 32'h0, 1'b0, 1'b0, "R7 zero on empty");
    step(1'b0, 8'h00, 32'h0, 1'b1, 1'b1, "R7 both engines");
    // mixed sweep in both modes
    for (int i = 0; i < 400; i++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      if (lfsr[3:0] == 4'h0) msi_en = ~msi_en;
      case (lfsr[6:4])
        3'd0, 3'd1: step(1'b1, 8'h60, lfsr & {lfsr[15:0], lfsr[31:16]}, lfsr[7], 1'b0, "R3 sweep");
        3'd2, 3'd3: step(1'b1, 8'h64, lfsr | {lfsr[7:0], lfsr[31:8]}, lfsr[7], lfsr[8], "R4 sweep");
        3'd4:       step(1'b0, 8'h00, 32'h0, lfsr[7], lfsr[8], "R5 sweep");
        3'd5:       step(1'b1, {lfsr[15:10], 2'b00}, lfsr, 1'b0, 1'b0, "R11 sweep");
        default:    step(1'b1, 8'h64, 32'hffff_ffff, 1'b0, 1'b0, "R9 sweep");
      endcase
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule